// File: doc/BRIEF.md
# Register File with Byte-Set Write Modes

This block holds the general-purpose registers of a small 16-bit load/store processor core. Two read ports are purely combinational, so the operand values for any two register indices appear in the same cycle the indices are presented. A single write port updates one register on the rising clock edge.

The write port takes a two-bit mode that selects how the new value is formed:
- A plain word write stores the full data input.
- The two byte-set modes drop an 8-bit immediate into either the upper or the lower half of the destination and keep the other half.
- The byte-load mode takes the low byte of the data input and fills the upper half with copies of its top bit.

Index zero is a constant zero source. Writes aimed at it are discarded.

The core's decoder drives the mode, the destination index, the data from the ALU or memory, and the immediate from the instruction word. Operands are read from the two read ports.

Top module: `regfile_bs`

## Requirements
- R1: The file holds 2**AW registers of DW bits (16 of 16 bits by default); read port A and read port B each return, combinationally, the register selected by their own index, independently of each other.
- R2: Index 0 always reads as all zeros on both read ports, whatever was written to it in any mode.
- R3: With write enable high and mode 2'b00 (word), the selected register takes the full write data at the rising clock edge.
- R4: With write enable high and mode 2'b01 (set high), bits DW-1:DW-8 of the selected register take the 8-bit immediate and bits DW-9:0 keep their value.
- R5: With write enable high and mode 2'b10 (set low), bits 7:0 of the selected register take the 8-bit immediate and bits DW-1:8 keep their value.
- R6: With write enable high and mode 2'b11 (byte load), bits 7:0 take write data bits 7:0 and every bit above takes write data bit 7.
- R7: With write enable low, no register changes, whatever the mode, index, data and immediate inputs carry.
- R8: A read of the index being written in the same cycle returns the value held before that clock edge; the new value is visible from the following cycle.
- R9: An active-low asynchronous reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ra_addr | input | AW | Read port A register index |
| rb_addr | input | AW | Read port B register index |
| ra_data | output | DW | Read port A value |
| rb_data | output | DW | Read port B value |
| we | input | 1 | Write enable |
| wa | input | AW | Write register index |
| wmode | input | 2 | Write mode: 00 word, 01 set high, 10 set low, 11 byte load |
| wdata | input | DW | Write data for the word and byte-load modes |
| wimm | input | 8 | Immediate byte for the set-high and set-low modes |

## Verification
The bench builds the block with its defaults, AW=4 and DW=16. With these values every one of the sixteen indices, including the highest index 15, can be written and read. The two byte halves meet exactly at bit 8, so a set-high followed by a set-low fully defines a register.

Because the sign-extended upper half is exactly one byte wide, byte loads with bit 7 set and clear give the two distinct fill patterns 8'hFF and 8'h00. A long pseudo-random stretch mixes all four modes with enabled and disabled writes and with reads of the index under write.

// File: rtl/regfile_bs.sv
module regfile_bs #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [1:0]    wmode,
  input  logic [DW-1:0] wdata,
  input  logic [7:0]    wimm
);
  localparam int NREG = 1 << AW;
  localparam int UPW  = DW - 8;
  localparam logic [1:0] M_WORD  = 2'b00;
  localparam logic [1:0] M_SETHI = 2'b01;
  localparam logic [1:0] M_SETLO = 2'b10;
  localparam logic [1:0] M_LDB   = 2'b11;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] cur;
  logic [DW-1:0] nxt;

  assign cur = regs[wa];

  always_comb begin
    case (wmode)
      M_WORD:  nxt = wdata;
      M_SETHI: nxt = {wimm, cur[UPW-1:0]};
      M_SETLO: nxt = {cur[DW-1:8], wimm};
      M_LDB:   nxt = {{UPW{wdata[7]}}, wdata[7:0]};
      default: nxt = wdata;
    endcase
  end

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (we && wa == AW'(i))
        q <= nxt;
    end
    assign regs[i] = q;
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
endmodule

// File: rtl/regfile_bs_chk.sv
module regfile_bs_chk #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ra_addr,
  input logic [AW-1:0] rb_addr,
  input logic [DW-1:0] ra_data,
  input logic [DW-1:0] rb_data,
  input logic          we,
  input logic [AW-1:0] wa,
  input logic [1:0]    wmode,
  input logic [DW-1:0] wdata,
  input logic [7:0]    wimm
);
  p_zero_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ra_addr == '0 |-> ra_data == '0);
  p_zero_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rb_addr == '0 |-> rb_data == '0);

  p_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we) && $past(wmode) == 2'b00 && $past(wa) != '0
     && ra_addr == $past(wa)) |-> ra_data == $past(wdata));

  p_sethi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we) && $past(wmode) == 2'b01 && $past(wa) != '0
     && ra_addr == $past(wa))
    |-> ra_data[DW-1:DW-8] == $past(wimm));
  p_sethi_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we) && $past(wmode) == 2'b01
     && $past(ra_addr) == $past(wa) && ra_addr == $past(ra_addr))
    |-> ra_data[DW-9:0] == $past(ra_data[DW-9:0]));

  p_setlo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we) && $past(wmode) == 2'b10 && $past(wa) != '0
     && ra_addr == $past(wa))
    |-> ra_data[7:0] == $past(wimm));
  p_setlo_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we) && $past(wmode) == 2'b10
     && $past(ra_addr) == $past(wa) && ra_addr == $past(ra_addr))
    |-> ra_data[DW-1:8] == $past(ra_data[DW-1:8]));

  p_ldb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we) && $past(wmode) == 2'b11 && $past(wa) != '0
     && ra_addr == $past(wa))
    |-> ra_data == {{(DW-8){$past(wdata[7])}}, $past(wdata[7:0])});

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(we) && rb_addr == $past(rb_addr))
    |-> rb_data == $past(rb_data));

  p_clear_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> (ra_data == '0 && rb_data == '0));
endmodule

bind regfile_bs regfile_bs_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/regfile_bs_test.sv
`timescale 1ns/1ps
module regfile_bs_test;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NREG = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ra_addr = '0, rb_addr = '0, wa = '0;
  logic [DW-1:0] ra_data, rb_data, wdata = '0;
  logic          we = 1'b0;
  logic [1:0]    wmode = 2'b00;
  logic [7:0]    wimm = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [DW-1:0] ea;
    logic [DW-1:0] eb;
    string         tag;
  } item_t;
  item_t sb[$];
  logic [DW-1:0] model [NREG];

  regfile_bs #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ra_addr(ra_addr), .rb_addr(rb_addr),
    .ra_data(ra_data), .rb_data(rb_data), .we(we), .wa(wa),
    .wmode(wmode), .wdata(wdata), .wimm(wimm));

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] expect_next(logic [DW-1:0] old,
      logic [1:0] md, logic [DW-1:0] d, logic [7:0] im);
    case (md)
      2'b00:   return d;
      2'b01:   return {im, old[7:0]};
      2'b10:   return {old[15:8], im};
      default: return {{8{d[7]}}, d[7:0]};
    endcase
  endfunction

  task automatic step(input bit w, input logic [AW-1:0] wi, input logic [1:0] md,
      input logic [DW-1:0] d, input logic [7:0] im,
      input logic [AW-1:0] a, input logic [AW-1:0] b, input string tag);
    item_t it;
    @(negedge clk);
    we = w; wa = wi; wmode = md; wdata = d; wimm = im;
    ra_addr = a; rb_addr = b;
    it.ea = model[a]; it.eb = model[b]; it.tag = tag;
    sb.push_back(it);
    if (w && wi != '0) model[wi] = expect_next(model[wi], md, d, im);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NREG; i++) model[i] = '0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (ra_data !== it.ea || rb_data !== it.eb) begin
          fails++;
          $display("FAIL %s: got a=%h b=%h expected a=%h b=%h",
                   it.tag, ra_data, rb_data, it.ea, it.eb);
        end
      end
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NREG; i++)
      step(0, '0, 2'b00, '0, '0, AW'(i), AW'(NREG-1-i), "R9 reset state");

    for (int i = 1; i < NREG; i++)
      step(1, AW'(i), 2'b00, 16'hA5C3 ^ (16'(i) * 16'h1111), 8'h00,
           AW'(i-1), AW'(i), "R3 word write");
    for (int i = 0; i < NREG; i++)
      step(0, '0, 2'b00, '0, '0, AW'(i), AW'(i ^ 5), "R1 two read ports");

    step(1, '0, 2'b00, 16'hFFFF, 8'hFF, 4'd0, 4'd0, "R2 word to r0");
    step(1, '0, 2'b01, 16'hFFFF, 8'hFF, 4'd0, 4'd0, "R2 sethi to r0");
    step(1, '0, 2'b11, 16'h00FF, 8'hFF, 4'd0, 4'd0, "R2 ldb to r0");
    step(0, '0, 2'b00, '0, '0, 4'd0, 4'd0, "R2 r0 still zero");

    step(1, 4'd5, 2'b01, 16'hFFFF, 8'h3C, 4'd5, 4'd4, "R4 sethi");
    step(0, '0, 2'b00, '0, '0, 4'd5, 4'd6, "R4 sethi keeps low byte");
    step(1, 4'd5, 2'b10, 16'hFFFF, 8'hC3, 4'd5, 4'd5, "R5 setlo");
    step(0, '0, 2'b00, '0, '0, 4'd5, 4'd15, "R5 setlo keeps high byte");

    step(1, 4'd7, 2'b11, 16'h1280, 8'h00, 4'd7, 4'd8, "R6 ldb negative");
    step(1, 4'd8, 2'b11, 16'hFF7F, 8'h00, 4'd7, 4'd8, "R6 ldb positive");
    step(0, '0, 2'b00, '0, '0, 4'd7, 4'd8, "R6 ldb results");

    step(0, 4'd5, 2'b00, 16'h0BAD, 8'h11, 4'd5, 4'd7, "R7 disabled word");
    step(0, 4'd7, 2'b01, 16'h0BAD, 8'h22, 4'd5, 4'd7, "R7 disabled sethi");
    step(0, 4'd15, 2'b11, 16'h0080, 8'h33, 4'd15, 4'd5, "R7 disabled ldb");
    step(0, '0, 2'b00, '0, '0, 4'd15, 4'd7, "R7 values unchanged");

    step(1, 4'd9, 2'b00, 16'h1234, 8'h00, 4'd9, 4'd9, "R8 read during write");
    step(1, 4'd9, 2'b10, 16'h0000, 8'h77, 4'd9, 4'd9, "R8 read during setlo");
    step(0, '0, 2'b00, '0, '0, 4'd9, 4'd9, "R8 new value visible");

    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[1], lf[5:2], lf[7:6], {lf[3:0], lf[15:4]}, lf[15:8],
           lf[11:8], lf[15:12], "R3/R4/R5/R6/R7 mix");
    end

    pulse_reset();
    for (int i = 0; i < NREG; i++)
      step(0, '0, 2'b00, '0, '0, AW'(i), AW'(NREG-1-i), "R9 cleared after reset");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule